// File: doc/BRIEF.md
# Programmed I/O Device Interface

This block is the bus-side front end of one peripheral on a minicomputer I/O bus. The processor presents a 17-bit I/O instruction on `io_instr` with a one-cycle `io_valid` strobe, along with the contents of its selected working register on `io_wdata`. The block claims the instruction only when the fixed opcode bits match and the 6-bit device field equals the `DEV_CODE` parameter. Every other instruction is ignored.

For a claimed instruction, the 3-bit mode field selects the action. It can return one of three 17-bit device registers, load one of them, or evaluate a skip test on the BUSY and DONE flags. The third register is the status register by convention. In every non-skip mode, the 2-bit function field also acts on the flags: it can start the device, stop it, or emit a one-cycle I/O pulse.

The peripheral reports completion on `dev_done`. This clears BUSY and sets DONE. The interrupt request is asserted while DONE is set and `int_mask` is low. A separate `io_reset` input returns the flags and the pulse to idle.

Top module: `pio_dev_if`

## Requirements
- R1: An instruction is claimed only when `io_valid` is 1, `io_instr[16:12]` is 5'b00001 and `io_instr[5:0]` equals `DEV_CODE`. When an instruction is not claimed:
  - `io_rd_en`, `io_rd_to_a`, `io_skip` and `io_rdata` are 0.
  - No register, flag or pulse changes.
- R2: For a claimed instruction with mode `io_instr[8:6]` of 1, 2 or 3, the following hold in the same cycle:
  - `io_rd_en` is 1.
  - `io_rdata` holds device register 1, 2 or 3 respectively.
  - `io_rd_to_a` equals `io_instr[11]`.
- R3: For a claimed instruction with mode 4, 5 or 6, device register 1, 2 or 3 respectively takes `io_wdata` at the next clock edge. The other registers keep their values, and nothing is driven on `io_rdata`.
- R4: For a claimed instruction in modes 0 to 6 with function `io_instr[10:9]` = 1, `busy` is 1 and `done` is 0 after the next edge.
- R5: For a claimed instruction in modes 0 to 6 with function 2, `busy` and `done` are both 0 after the next edge.
- R6: For a claimed instruction in modes 0 to 6 with function 3, `io_pulse` is 1 for exactly the cycle after the edge, and the flags are unchanged. `io_pulse` is 0 otherwise.
- R7: For a claimed instruction in mode 7, `io_skip` is driven in the same cycle according to the function field, and no flag or register changes:
  - function 0: `io_skip` equals `busy`;
  - function 1: `io_skip` equals not `busy`;
  - function 2: `io_skip` equals `done`;
  - function 3: `io_skip` equals not `done`.
- R8: A `dev_done` pulse clears `busy` and sets `done` at the next edge.
- R9: When `dev_done` coincides with a claimed function 1 or 2, the command decides the flags. With function 0, function 3 or a skip, `dev_done` takes effect.
- R10: `int_req` equals `done` AND NOT `int_mask` at all times.
- R11: `io_reset` clears `busy`, `done` and `io_pulse` at the next edge, overriding any command or completion. Device register writes in that cycle still take effect.
- R12: While `rst_n` is 0, the flags, `io_pulse`, `int_req` and all device registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid | input | 1 | Instruction present this cycle |
| io_instr | input | 17 | I/O instruction word |
| io_wdata | input | 17 | Processor register value for writes |
| io_reset | input | 1 | Bus-wide I/O reset |
| int_mask | input | 1 | 1 blocks the interrupt request |
| dev_done | input | 1 | Device completion strobe |
| io_rd_en | output | 1 | Block drives read data this cycle |
| io_rd_to_a | output | 1 | Read data goes to register A (else B) |
| io_rdata | output | 17 | Read data, 0 when not reading |
| io_skip | output | 1 | Skip condition met |
| busy | output | 1 | BUSY flag |
| done | output | 1 | DONE flag |
| int_req | output | 1 | Interrupt request |
| io_pulse | output | 1 | One-cycle I/O pulse to the device |
| dev_reg1 | output | 17 | Device register 1 |
| dev_reg2 | output | 17 | Device register 2 |
| dev_reg3 | output | 17 | Device register 3 (status) |

## Verification
The processor's start or stop function and the device's completion strobe can arrive in the same cycle, and they act on the same two flags. The bench provokes this by first making the device busy. It then issues each of the four function codes with `dev_done` raised alongside. Each outcome is judged against R9: start and stop decide the flags, while no-operation and pulse let completion through. `io_reset` is also overlapped with a pulse command, a write and a completion, to confirm that it wins over all of them except the register write.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int WORD_W = 17;
    localparam int CODE_W = 6;
    localparam int NREG   = 3;
    localparam int IDX_W  = $clog2(NREG + 1);
    localparam logic [4:0] IO_OPC = 5'b00001;

    typedef enum logic [1:0] {
        FN_NONE  = 2'd0,
        FN_START = 2'd1,
        FN_STOP  = 2'd2,
        FN_PULSE = 2'd3
    } io_fn_e;

    typedef struct packed {
        logic             hit;
        logic             is_read;
        logic             is_write;
        logic             is_skip;
        logic             to_a;
        logic [IDX_W-1:0] ridx;
        io_fn_e           fn;
    } io_cmd_t;

    typedef struct packed {
        logic busy;
        logic done;
        logic pulse;
    } flag_t;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter logic [CODE_W-1:0] DEV_CODE = 6'd24
) (
    input  logic              io_valid,
    input  logic [WORD_W-1:0] io_instr,
    output io_cmd_t           cmd
);

    logic [2:0] mode;
    logic       match;

    assign mode  = io_instr[8:6];
    assign match = io_valid && (io_instr[16:12] == IO_OPC)
                   && (io_instr[CODE_W-1:0] == DEV_CODE);

    always_comb begin
        cmd          = '0;
        cmd.hit      = match;
        cmd.is_read  = match && (mode >= 3'd1) && (mode <= 3'd3);
        cmd.is_write = match && (mode >= 3'd4) && (mode <= 3'd6);
        cmd.is_skip  = match && (mode == 3'd7);
        cmd.to_a     = io_instr[11];
        cmd.fn       = io_fn_e'(io_instr[10:9]);
        if (mode[2]) begin
            cmd.ridx = IDX_W'(mode[1:0]);
        end else begin
            cmd.ridx = IDX_W'(mode[1:0] - 2'd1);
        end
    end

endmodule

// File: rtl/pio_flags.sv
module pio_flags
    import pio_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fn_en,
    input  io_fn_e fn,
    input  logic   dev_done,
    input  logic   io_reset,
    output flag_t  flags
);

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.pulse = 1'b0;
        if (dev_done) begin
            fl_d.busy = 1'b0;
            fl_d.done = 1'b1;
        end
        if (fn_en) begin
            unique case (fn)
                FN_START: begin
                    fl_d.busy = 1'b1;
                    fl_d.done = 1'b0;
                end
                FN_STOP: begin
                    fl_d.busy = 1'b0;
                    fl_d.done = 1'b0;
                end
                FN_PULSE: fl_d.pulse = 1'b1;
                FN_NONE:  ;
            endcase
        end
        if (io_reset) begin
            fl_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
    import pio_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W-1:0]           rdata,
    output logic [NREG-1:0][WORD_W-1:0] regs
);

    logic [NREG-1:0][WORD_W-1:0] regs_d, regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (idx == IDX_W'(g))) begin
                regs_d[g] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (idx == IDX_W'(i)) begin
                rdata = regs_q[i];
            end
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/pio_dev_if.sv
module pio_dev_if
    import pio_pkg::*;
#(
    parameter logic [5:0] DEV_CODE = 6'd24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_valid,
    input  logic [16:0] io_instr,
    input  logic [16:0] io_wdata,
    input  logic        io_reset,
    input  logic        int_mask,
    input  logic        dev_done,
    output logic        io_rd_en,
    output logic        io_rd_to_a,
    output logic [16:0] io_rdata,
    output logic        io_skip,
    output logic        busy,
    output logic        done,
    output logic        int_req,
    output logic        io_pulse,
    output logic [16:0] dev_reg1,
    output logic [16:0] dev_reg2,
    output logic [16:0] dev_reg3
);

    io_cmd_t                     cmd;
    flag_t                       flags;
    logic [WORD_W-1:0]           rd_word;
    logic [NREG-1:0][WORD_W-1:0] regs;
    logic                        skip_cond;

    pio_decode #(.DEV_CODE(DEV_CODE)) u_dec (
        .io_valid (io_valid),
        .io_instr (io_instr),
        .cmd      (cmd)
    );

    pio_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_en    (cmd.hit && !cmd.is_skip),
        .fn       (cmd.fn),
        .dev_done (dev_done),
        .io_reset (io_reset),
        .flags    (flags)
    );

    pio_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cmd.is_write),
        .idx   (cmd.ridx),
        .wdata (io_wdata),
        .rdata (rd_word),
        .regs  (regs)
    );

    always_comb begin
        unique case (cmd.fn)
            FN_NONE:  skip_cond = flags.busy;
            FN_START: skip_cond = !flags.busy;
            FN_STOP:  skip_cond = flags.done;
            FN_PULSE: skip_cond = !flags.done;
        endcase
    end

    assign io_rd_en   = cmd.is_read;
    assign io_rd_to_a = cmd.is_read && cmd.to_a;
    assign io_rdata   = cmd.is_read ? rd_word : '0;
    assign io_skip    = cmd.is_skip && skip_cond;
    assign busy       = flags.busy;
    assign done       = flags.done;
    assign io_pulse   = flags.pulse;
    assign int_req    = flags.done && !int_mask;
    assign dev_reg1   = regs[0];
    assign dev_reg2   = regs[1];
    assign dev_reg3   = regs[2];

endmodule

// File: rtl/pio_dev_if_chk.sv
module pio_dev_if_chk #(
    parameter logic [5:0] DEV_CODE = 6'd24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        io_valid,
    input logic [16:0] io_instr,
    input logic        io_reset,
    input logic        int_mask,
    input logic        dev_done,
    input logic        io_rd_en,
    input logic        io_skip,
    input logic        busy,
    input logic        done,
    input logic        int_req,
    input logic        io_pulse
);

    logic       sel;
    logic [2:0] md;
    logic [1:0] fc;
    logic       flag_cmd;

    assign sel      = io_valid && (io_instr[16:12] == 5'b00001) && (io_instr[5:0] == DEV_CODE);
    assign md       = io_instr[8:6];
    assign fc       = io_instr[10:9];
    assign flag_cmd = sel && (md != 3'd7) && ((fc == 2'd1) || (fc == 2'd2));

    AST_FOREIGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!io_rd_en && !io_skip)); // R1

    AST_SKIP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        io_skip |-> !io_rd_en); // R7

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && md != 3'd7 && fc == 2'd1 && !io_reset) |=> (busy && !done)); // R4

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && md != 3'd7 && fc == 2'd2) |=> (!busy && !done)); // R5

    AST_COMPLETE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_done && !flag_cmd && !io_reset) |=> (!busy && done)); // R8

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_pulse |-> $past(sel && md != 3'd7 && fc == 2'd3 && !io_reset)); // R6

    AST_IORESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        io_reset |=> (!busy && !done && !io_pulse)); // R11

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (done && !int_mask)); // R10

    AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R9

endmodule

bind pio_dev_if pio_dev_if_chk #(.DEV_CODE(DEV_CODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_valid (io_valid),
    .io_instr (io_instr),
    .io_reset (io_reset),
    .int_mask (int_mask),
    .dev_done (dev_done),
    .io_rd_en (io_rd_en),
    .io_skip  (io_skip),
    .busy     (busy),
    .done     (done),
    .int_req  (int_req),
    .io_pulse (io_pulse)
);

// File: tb/sim_pio_dev_if.sv
`timescale 1ns/1ps
module sim_pio_dev_if;

    localparam logic [5:0] DEV = 6'd24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic [16:0] io_instr = '0;
    logic [16:0] io_wdata = '0;
    logic        io_reset = 1'b0;
    logic        int_mask = 1'b0;
    logic        dev_done = 1'b0;
    logic        io_rd_en, io_rd_to_a, io_skip, busy, done, int_req, io_pulse;
    logic [16:0] io_rdata, dev_reg1, dev_reg2, dev_reg3;

    int n_chk = 0;
    int n_fail = 0;

    logic        e_busy = 1'b0, e_done = 1'b0;
    logic [16:0] e_reg [3];

    always #4 clk = ~clk;

    pio_dev_if #(.DEV_CODE(DEV)) u0 (.*);

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] mk(input logic [2:0] m, input logic [1:0] f, input logic a);
        return {5'b00001, a, f, m, DEV};
    endfunction

    task automatic issue(input logic [16:0] ins, input logic [16:0] wd,
                         input logic strb, input logic rst_io);
        logic hit, rd, sk, pls;
        logic [2:0] m;
        logic [1:0] f;
        logic [16:0] exp_rd;
        @(negedge clk);
        io_valid = 1'b1; io_instr = ins; io_wdata = wd;
        dev_done = strb; io_reset = rst_io;
        #1;
        m = ins[8:6]; f = ins[10:9];
        hit = (ins[16:12] == 5'b00001) && (ins[5:0] == DEV);
        rd = hit && (m >= 3'd1) && (m <= 3'd3);
        exp_rd = rd ? e_reg[m - 3'd1] : 17'd0;
        case (f)
            2'd0: sk = e_busy;
            2'd1: sk = !e_busy;
            2'd2: sk = e_done;
            default: sk = !e_done;
        endcase
        sk = sk && hit && (m == 3'd7);
        chk(io_rd_en == rd, hit ? "R2 rd_en" : "R1 rd_en", io_rd_en, rd);
        chk(io_rdata == exp_rd, hit ? "R2 rdata" : "R1 rdata", io_rdata, exp_rd);
        chk(io_rd_to_a == (rd && ins[11]), "R2 to_a", io_rd_to_a, rd && ins[11]);
        chk(io_skip == sk, hit ? "R7 skip" : "R1 skip", io_skip, sk);
        // model update
        if (hit && m >= 3'd4 && m <= 3'd6) e_reg[m - 3'd4] = wd;
        if (strb) begin e_busy = 1'b0; e_done = 1'b1; end
        pls = 1'b0;
        if (hit && m != 3'd7) begin
            if (f == 2'd1) begin e_busy = 1'b1; e_done = 1'b0; end
            else if (f == 2'd2) begin e_busy = 1'b0; e_done = 1'b0; end
            else if (f == 2'd3) pls = 1'b1;
        end
        if (rst_io) begin e_busy = 1'b0; e_done = 1'b0; pls = 1'b0; end
        @(negedge clk);
        io_valid = 1'b0; dev_done = 1'b0; io_reset = 1'b0;
        #1;
        chk(busy == e_busy, "R4/R5/R8/R9/R11 busy", busy, e_busy);
        chk(done == e_done, "R4/R5/R8/R9/R11 done", done, e_done);
        chk(io_pulse == pls, "R6 pulse", io_pulse, pls);
        chk(dev_reg1 == e_reg[0], "R3 reg1", dev_reg1, e_reg[0]);
        chk(dev_reg2 == e_reg[1], "R3 reg2", dev_reg2, e_reg[1]);
        chk(dev_reg3 == e_reg[2], "R3 reg3", dev_reg3, e_reg[2]);
        chk(int_req == (e_done && !int_mask), "R10 int_req", int_req, e_done && !int_mask);
    endtask

    task automatic set_state(input int st);
        issue(mk(3'd0, 2'd2, 1'b0), 17'd0, 1'b0, 1'b0);
        if (st >= 1) issue(mk(3'd0, 2'd1, 1'b0), 17'd0, 1'b0, 1'b0);
        if (st == 2) issue(mk(3'd0, 2'd0, 1'b0), 17'd0, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) e_reg[i] = '0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(busy == 1'b0 && done == 1'b0, "R12 flags", {busy, done}, 0);
        chk(io_pulse == 1'b0 && int_req == 1'b0, "R12 pulse/irq", {io_pulse, int_req}, 0);
        chk(dev_reg1 == 0 && dev_reg2 == 0 && dev_reg3 == 0, "R12 regs",
            dev_reg1 | dev_reg2 | dev_reg3, 0);
        rst_n = 1'b1;

        // Sweep every mode and function from each reachable flag state (R2-R7)
        for (int st = 0; st < 3; st++) begin
            for (int m = 0; m < 8; m++) begin
                for (int f = 0; f < 4; f++) begin
                    set_state(st);
                    issue(mk(3'(m), 2'(f), 1'((m + f + st) % 2)),
                          17'((st * 4099 + m * 517 + f * 73 + 1) * 37), 1'b0, 1'b0);
                end
            end
        end

        // R1: every foreign device code, write+start and skip
        set_state(2);
        for (int c = 0; c < 64; c++) begin
            if (6'(c) != DEV) begin
                issue({5'b00001, 1'b1, 2'd1, 3'd4, 6'(c)}, 17'h1ABCD, 1'b0, 1'b0);
                issue({5'b00001, 1'b0, 2'd2, 3'd7, 6'(c)}, 17'h0, 1'b0, 1'b0);
            end
        end
        // R1: wrong opcode bits with the right device code
        for (int op = 0; op < 32; op++) begin
            if (op != 1) issue({5'(op), 1'b1, 2'd1, 3'd2, DEV}, 17'h0F0F0, 1'b0, 1'b0);
        end

        // R9: completion coinciding with each function
        for (int f = 0; f < 4; f++) begin
            set_state(1);
            issue(mk(3'd0, 2'(f), 1'b0), 17'd0, 1'b1, 1'b0);
            set_state(1);
            issue(mk(3'd7, 2'(f), 1'b0), 17'd0, 1'b1, 1'b0);
        end

        // R11: io_reset with pulse + write + completion, and with start
        set_state(2);
        issue(mk(3'd5, 2'd3, 1'b0), 17'h15555, 1'b1, 1'b1);
        issue(mk(3'd0, 2'd1, 1'b0), 17'd0, 1'b0, 1'b1);

        // R10: mask gating against both DONE values
        for (int d = 0; d < 2; d++) begin
            set_state(d == 1 ? 2 : 0);
            for (int k = 0; k < 2; k++) begin
                int_mask = 1'(k);
                issue(mk(3'd7, 2'd0, 1'b0), 17'd0, 1'b0, 1'b0);
            end
        end
        int_mask = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule